// File: doc/BRIEF.md
# Fixed-Priority Nested Interrupt Controller

This controller collects thirty-two external request lines and offers at most one interrupt to a processor core. Each line has a fixed vector: line n is vector 32+n. A larger vector means a higher priority. The controller keeps two bit sets. The pending set holds requests that have arrived. The in-service set holds requests the core has taken but not yet retired. A pending request is offered only if it outranks everything in service. A more urgent line therefore nests on top of a less urgent one. A less urgent line waits until software retires the current handler with an end-of-interrupt write.

Per-line masking and the choice between edge and level sensing come from a neighbouring redirection block, on the `line_mask` and `line_level` inputs. A small register window provides the following controls:
- a global enable,
- a priority threshold,
- the end-of-interrupt strobe,
- a read-only view of the in-service set,
- a timer entry that steers a timer event onto one of the lower sixteen lines.

The core takes an offered vector by pulsing `int_ack` while `int_req` is high.

Top module: `prio_intc`

## Requirements
- R1: Line n is always offered with vector 32+n on `int_vec` (n = 0..31); the vector cannot be reprogrammed.
- R2: When several eligible lines are pending and nothing is in service, the line with the highest index is offered.
- R3: A pending line is offered only if its index is above every in-service index. An equal or lower line stays pending and is not offered.
- R4: A write to offset 0x0B0 clears only the highest set in-service bit. The next highest eligible pending line is then offered if it outranks what remains. A write with an empty in-service set changes nothing.
- R5: A read at offset 0x110 returns the in-service set, with bit n meaning vector 32+n is in service.
- R6: Bit 8 of the control register at offset 0x0F0 is the global enable, and it resets to 0. While it is 0, `int_req` stays low, but pending bits are kept and offered once it is set.
- R7: The threshold register at offset 0x080 resets to 0. A line is offered only if bits [7:4] of its vector are greater than bits [7:4] of this register.
- R8: The timer entry at offset 0x320 holds a line number in bits [3:0] and a mask in bit 16, and resets to 0x0001_0000. A `timer_evt` pulse sets the pending bit of the selected line only while bit 16 is 0.
- R9: On an edge-mode line (`line_level` bit 0), a rising input sets the pending bit. On a level-mode line (bit 1), the pending bit follows the input being high and the line being unmasked.
- R10: When `int_ack` is high while `int_req` is high, the offered line's pending bit is cleared and its in-service bit is set at the same clock edge.
- R11: A line with its `line_mask` bit at 1 is never offered. A rising edge that arrives while the line is masked is not recorded. A pending bit recorded before masking is offered again after unmasking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | External request lines |
| line_mask | input | 32 | Per-line mask from the redirection block (1 = masked) |
| line_level | input | 32 | Per-line sense mode (1 = level, 0 = edge) |
| timer_evt | input | 1 | Timer event pulse to steer onto the selected line |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| int_req | output | 1 | An interrupt is offered to the core |
| int_vec | output | 8 | Offered vector; 0 when `int_req` is low |
| int_ack | input | 1 | Core takes the offered vector |

## Verification
The checker verifies, on every cycle, the rules that hold for any offered request:
- a request is offered only while the controller is enabled;
- the offered vector lies in 32..63;
- the offered vector is above every in-service bit;
- the offered vector is above the threshold class.

It also verifies how the in-service set changes: an acknowledge adds exactly the offered bit, an end-of-interrupt removes exactly one bit, and an end-of-interrupt with an empty set leaves it empty.

Some behaviour can only be shown by the bench's scenarios, because it depends on history. This covers:
- which pending line wins among several;
- that a lower line waits and is then released by an end-of-interrupt write;
- the difference between edge and level sensing;
- edges that are lost while a line is masked;
- timer steering.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

    localparam int NUM_LINES = 32;
    localparam int IDX_W     = $clog2(NUM_LINES);
    localparam int VEC_W     = 8;
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int TSEL_W    = 4;

    localparam logic [ADDR_W-1:0] OFS_THRESH = 12'h080;
    localparam logic [ADDR_W-1:0] OFS_EOI    = 12'h0B0;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h0F0;
    localparam logic [ADDR_W-1:0] OFS_INSVC  = 12'h110;
    localparam logic [ADDR_W-1:0] OFS_TIMER  = 12'h320;

    localparam int CTRL_EN_BIT   = 8;
    localparam int TMR_MASK_BIT  = 16;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } pick_t;

    typedef struct packed {
        logic              enable;
        logic [VEC_W-1:0]  thresh;
        logic [TSEL_W-1:0] tmr_line;
        logic              tmr_mask;
    } cfg_t;

    function automatic pick_t top_bit(input logic [NUM_LINES-1:0] v);
        pick_t r;
        r = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (v[i]) begin
                r.valid = 1'b1;
                r.idx   = IDX_W'(i);
            end
        end
        return r;
    endfunction

    function automatic logic [NUM_LINES-1:0] one_hot(input pick_t p);
        logic [NUM_LINES-1:0] r;
        r = '0;
        if (p.valid) r[p.idx] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/prio_intc_line.sv
module prio_intc_line (
    input  logic clk,
    input  logic rst,
    input  logic irq,
    input  logic mask,
    input  logic level,
    input  logic inject,
    input  logic take,
    output logic pend
);
    logic prev_q;
    logic rise;

    assign rise = irq & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            prev_q <= irq;
            if (take) begin
                pend <= 1'b0;
            end else if (level) begin
                pend <= (irq & ~mask) | inject;
            end else if ((rise & ~mask) | inject) begin
                pend <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb
    import prio_intc_pkg::*;
#(
    parameter int VEC_BASE = 32
) (
    input  logic [NUM_LINES-1:0] pend,
    input  logic [NUM_LINES-1:0] mask,
    input  logic [NUM_LINES-1:0] insvc,
    input  cfg_t                 cfg,
    output logic                 req,
    output logic [VEC_W-1:0]     vec,
    output pick_t                win
);
    pick_t            cand;
    pick_t            busy;
    logic [VEC_W-1:0] cand_vec;
    logic             above_busy;
    logic             class_ok;

    always_comb begin
        cand       = top_bit(pend & ~mask);
        busy       = top_bit(insvc);
        cand_vec   = VEC_W'(VEC_BASE) + VEC_W'(cand.idx);
        above_busy = !busy.valid || (cand.idx > busy.idx);
        class_ok   = cand_vec[VEC_W-1:4] > cfg.thresh[VEC_W-1:4];
        req        = cfg.enable & cand.valid & above_busy & class_ok;
        vec        = req ? cand_vec : '0;
        win        = cand;
    end
endmodule

// File: rtl/prio_intc_regs.sv
module prio_intc_regs
    import prio_intc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic                 take,
    input  pick_t                take_pick,
    output cfg_t                 cfg,
    output logic [NUM_LINES-1:0] insvc,
    output logic                 eoi_hit
);
    logic [NUM_LINES-1:0] retire_mask;
    logic [NUM_LINES-1:0] admit_mask;
    logic                 unused_wdata;

    assign unused_wdata = ^{bus_wdata[DATA_W-1:TMR_MASK_BIT+1],
                            bus_wdata[TMR_MASK_BIT-1:CTRL_EN_BIT+1]};

    assign eoi_hit     = bus_we && (bus_addr == OFS_EOI);
    assign retire_mask = eoi_hit ? one_hot(top_bit(insvc)) : '0;
    assign admit_mask  = take ? one_hot(take_pick) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.enable   <= 1'b0;
            cfg.thresh   <= '0;
            cfg.tmr_line <= '0;
            cfg.tmr_mask <= 1'b1;
            insvc        <= '0;
        end else begin
            insvc <= (insvc & ~retire_mask) | admit_mask;
            if (bus_we) begin
                case (bus_addr)
                    OFS_CTRL:   cfg.enable <= bus_wdata[CTRL_EN_BIT];
                    OFS_THRESH: cfg.thresh <= bus_wdata[VEC_W-1:0];
                    OFS_TIMER: begin
                        cfg.tmr_line <= bus_wdata[TSEL_W-1:0];
                        cfg.tmr_mask <= bus_wdata[TMR_MASK_BIT];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL:   bus_rdata[CTRL_EN_BIT] = cfg.enable;
            OFS_THRESH: bus_rdata[VEC_W-1:0]   = cfg.thresh;
            OFS_INSVC:  bus_rdata[NUM_LINES-1:0] = insvc;
            OFS_TIMER: begin
                bus_rdata[TSEL_W-1:0]   = cfg.tmr_line;
                bus_rdata[TMR_MASK_BIT] = cfg.tmr_mask;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int VEC_BASE = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [NUM_LINES-1:0] line_mask,
    input  logic [NUM_LINES-1:0] line_level,
    input  logic                 timer_evt,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 int_req,
    output logic [VEC_W-1:0]     int_vec,
    input  logic                 int_ack
);
    cfg_t                 cfg_q;
    logic [NUM_LINES-1:0] insvc_q;
    logic [NUM_LINES-1:0] pend_q;
    logic                 eoi_hit;
    logic                 take;
    pick_t                win;

    assign take = int_req & int_ack;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic inj;
        logic clr;
        assign inj = timer_evt & ~cfg_q.tmr_mask &
                     (IDX_W'(cfg_q.tmr_line) == IDX_W'(i));
        assign clr = take && (win.idx == IDX_W'(i));
        prio_intc_line u_line (
            .clk    (clk),
            .rst    (rst),
            .irq    (irq_in[i]),
            .mask   (line_mask[i]),
            .level  (line_level[i]),
            .inject (inj),
            .take   (clr),
            .pend   (pend_q[i])
        );
    end

    prio_intc_arb #(.VEC_BASE(VEC_BASE)) u_arb (
        .pend  (pend_q),
        .mask  (line_mask),
        .insvc (insvc_q),
        .cfg   (cfg_q),
        .req   (int_req),
        .vec   (int_vec),
        .win   (win)
    );

    prio_intc_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .take      (take),
        .take_pick (win),
        .cfg       (cfg_q),
        .insvc     (insvc_q),
        .eoi_hit   (eoi_hit)
    );
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk
    import prio_intc_pkg::*;
#(
    parameter int VEC_BASE = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 int_req,
    input logic [VEC_W-1:0]     int_vec,
    input logic                 int_ack,
    input logic [NUM_LINES-1:0] insvc,
    input logic                 enable,
    input logic [VEC_W-1:0]     thresh,
    input logic                 eoi
);
    logic [IDX_W-1:0] vidx;
    logic             took;
    assign vidx = IDX_W'(int_vec - VEC_W'(VEC_BASE));
    assign took = int_req & int_ack;

    a_r6_req_needs_enable: assert property (@(posedge clk) disable iff (rst)
        int_req |-> enable);

    a_r1_vec_range: assert property (@(posedge clk) disable iff (rst)
        int_req |-> (int_vec >= VEC_W'(VEC_BASE)) &&
                    (int_vec < VEC_W'(VEC_BASE + NUM_LINES)));

    a_r3_above_insvc: assert property (@(posedge clk) disable iff (rst)
        int_req |-> ((insvc >> vidx) == '0));

    a_r7_class_above: assert property (@(posedge clk) disable iff (rst)
        int_req |-> (int_vec[VEC_W-1:4] > thresh[VEC_W-1:4]));

    a_r10_ack_admits: assert property (@(posedge clk) disable iff (rst)
        (took && !eoi) |=> insvc[$past(vidx)] &&
            ($countones(insvc) == $past($countones(insvc)) + 1));

    a_r4_eoi_empty: assert property (@(posedge clk) disable iff (rst)
        (eoi && insvc == '0 && !took) |=> insvc == '0);

    a_r4_eoi_retires_one: assert property (@(posedge clk) disable iff (rst)
        (eoi && insvc != '0 && !took) |=>
            ($countones(insvc) + 1 == $past($countones(insvc))));
endmodule

bind prio_intc prio_intc_chk #(.VEC_BASE(VEC_BASE)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .int_req (int_req),
    .int_vec (int_vec),
    .int_ack (int_ack),
    .insvc   (insvc_q),
    .enable  (cfg_q.enable),
    .thresh  (cfg_q.thresh),
    .eoi     (eoi_hit)
);

// File: tb/sim_prio_intc.sv
module sim_prio_intc;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_THR = 12'h080;
    localparam logic [11:0] A_EOI = 12'h0B0;
    localparam logic [11:0] A_CTL = 12'h0F0;
    localparam logic [11:0] A_ISR = 12'h110;
    localparam logic [11:0] A_TMR = 12'h320;

    logic        clk = 0;
    logic        rst = 1;
    logic [31:0] irq_in = '0, line_mask = '0, line_level = '0;
    logic        timer_evt = 0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        int_req;
    logic [7:0]  int_vec;
    logic        int_ack = 0;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_intc u0 (
        .clk(clk), .rst(rst), .irq_in(irq_in), .line_mask(line_mask),
        .line_level(line_level), .timer_evt(timer_evt), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .int_req(int_req), .int_vec(int_vec), .int_ack(int_ack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input int n);
        irq_in[n] = 1;
        @(negedge clk);
        irq_in[n] = 0;
    endtask

    task automatic ack();
        int_ack = 1;
        @(negedge clk);
        int_ack = 0;
    endtask

    task automatic drain();
        for (int k = 0; k < 64; k++) begin
            if (!int_req) break;
            ack();
            wr(A_EOI, 0);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [31:0] pats [4];
        pats[0] = 32'h0000_0011; pats[1] = 32'h8000_0001;
        pats[2] = 32'h0F0F_0000; pats[3] = 32'h0000_0300;

        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // reset state
        chk("R6 reset req", {31'b0, int_req}, 0);
        rd(A_CTL, r); chk("R6 reset ctrl", r, 0);
        rd(A_THR, r); chk("R7 reset thresh", r, 0);
        rd(A_ISR, r); chk("R5 reset insvc", r, 0);
        rd(A_TMR, r); chk("R8 reset timer", r, 32'h0001_0000);

        // disabled: pending kept
        pulse(5);
        chk("R6 disabled no req", {31'b0, int_req}, 0);
        wr(A_CTL, 32'h100);
        rd(A_CTL, r); chk("R6 ctrl readback", r, 32'h100);
        chk("R6 released req", {31'b0, int_req}, 1);
        chk("R6 released vec", {24'b0, int_vec}, 37);
        drain();

        // R4 end-of-interrupt on empty set
        wr(A_EOI, 0);
        rd(A_ISR, r); chk("R4 eoi empty", r, 0);

        // per-line sweep
        for (int n = 0; n < 32; n++) begin
            pulse(n);
            chk("R1 req", {31'b0, int_req}, 1);
            chk("R1 vec", {24'b0, int_vec}, 32 + n);
            ack();
            chk("R10 req after ack", {31'b0, int_req}, 0);
            rd(A_ISR, r); chk("R5 insvc bit", r, 32'h1 << n);
            wr(A_EOI, 0);
            rd(A_ISR, r); chk("R4 insvc cleared", r, 0);
        end

        // R2 highest pending wins
        foreach (pats[p]) begin
            int top;
            top = 0;
            for (int b = 0; b < 32; b++) if (pats[p][b]) top = b;
            irq_in = pats[p];
            @(negedge clk);
            irq_in = '0;
            chk("R2 vec", {24'b0, int_vec}, 32 + top);
            drain();
            rd(A_ISR, r); chk("R2 drained", r, 0);
        end

        // R3 nesting and holding
        for (int lo = 0; lo < 16; lo++) begin
            int hi;
            hi = 31 - lo;
            pulse(lo); ack();
            pulse(hi);
            chk("R3 preempt req", {31'b0, int_req}, 1);
            chk("R3 preempt vec", {24'b0, int_vec}, 32 + hi);
            ack();
            rd(A_ISR, r); chk("R3 nested insvc", r, (32'h1 << lo) | (32'h1 << hi));
            pulse(lo);
            chk("R3 lower held", {31'b0, int_req}, 0);
            wr(A_EOI, 0);
            rd(A_ISR, r); chk("R4 top retired", r, 32'h1 << lo);
            chk("R3 equal held", {31'b0, int_req}, 0);
            wr(A_EOI, 0);
            chk("R4 next released", {24'b0, int_vec}, 32 + lo);
            ack(); wr(A_EOI, 0);
        end

        // R7 threshold class
        wr(A_THR, 32'h20);
        rd(A_THR, r); chk("R7 thresh readback", r, 32'h20);
        for (int n = 0; n < 32; n++) begin
            pulse(n);
            chk("R7 gate", {31'b0, int_req}, (n >= 16) ? 1 : 0);
            if (n >= 16) chk("R7 vec", {24'b0, int_vec}, 32 + n);
            drain();
        end
        wr(A_THR, 32'h0);
        chk("R7 lowered vec", {24'b0, int_vec}, 47);
        drain();
        wr(A_THR, 32'h30);
        pulse(31);
        chk("R7 top blocked", {31'b0, int_req}, 0);
        wr(A_THR, 32'h0);
        chk("R7 top released", {24'b0, int_vec}, 63);
        drain();

        // R9 level sensing
        line_level[7] = 1;
        irq_in[7] = 1;
        @(negedge clk);
        chk("R9 level vec", {24'b0, int_vec}, 39);
        ack();
        chk("R9 level in service", {31'b0, int_req}, 0);
        wr(A_EOI, 0);
        chk("R9 level re-offered", {24'b0, int_vec}, 39);
        ack();
        irq_in[7] = 0;
        wr(A_EOI, 0);
        chk("R9 level dropped", {31'b0, int_req}, 0);
        irq_in[7] = 1;
        @(negedge clk);
        irq_in[7] = 0;
        @(negedge clk);
        chk("R9 level gone before ack", {31'b0, int_req}, 0);
        line_level[7] = 0;

        // R11 masking
        line_mask[3] = 1;
        pulse(3);
        chk("R11 masked not offered", {31'b0, int_req}, 0);
        line_mask[3] = 0;
        @(negedge clk);
        chk("R11 edge lost", {31'b0, int_req}, 0);
        pulse(4);
        line_mask[4] = 1;
        @(negedge clk);
        chk("R11 masked pending hidden", {31'b0, int_req}, 0);
        line_mask[4] = 0;
        @(negedge clk);
        chk("R11 pending kept", {24'b0, int_vec}, 36);
        drain();

        // R8 timer steering
        timer_evt = 1; @(negedge clk); timer_evt = 0;
        chk("R8 timer masked", {31'b0, int_req}, 0);
        wr(A_TMR, 32'h0000_0009);
        rd(A_TMR, r); chk("R8 timer readback", r, 32'h9);
        timer_evt = 1; @(negedge clk); timer_evt = 0;
        chk("R8 timer vec", {24'b0, int_vec}, 41);
        drain();
        rd(A_ISR, r); chk("R4 final insvc", r, 0);

        summary();
        $finish;
    end
endmodule